// File: doc/BRIEF.md
# Converter Serial Register Port

This block is the two-wire serial slave that sits in front of a data converter. It samples the clock and data lines of an I2C bus with the system clock, decodes START and STOP conditions, and pulls the data line low through an open-drain enable. It keeps the converter's 8-bit configuration register. On a read it returns the latest 16-bit conversion result and then the configuration byte.

A master addresses the block with the 7-bit pattern `1001` followed by three parameter bits. A write transfer changes the configuration with its first data byte. A configuration byte whose top bit is set also produces a one-cycle start-conversion pulse. The block also answers the bus-wide general-call reset. It recognizes the high-speed master code and raises a flag that lasts until the next STOP.

Top module: `conv_i2c_slave`

## Requirements
- R1: An address byte whose upper seven bits equal `1001` followed by `ADDR_LOW` is acknowledged. Any other address byte that is neither 00H nor a high-speed code is not acknowledged and has no effect.
- R2: A read (address bit 0 = 1) returns the result bits 15..8 first, then result bits 7..0, then the configuration byte. The result is sampled when the address is decoded.
- R3: Every byte the master reads after the third one is FFH.
- R4: In a write transfer, the first data byte is acknowledged and loaded into the configuration register, with bits 6 and 5 forced to 0. If bit 7 of that byte is 1, `conv_start_o` pulses high for exactly one cycle.
- R5: Data bytes after the first in a write transfer are not acknowledged and leave the configuration unchanged.
- R6: The general-call address 00H is always acknowledged. A following data byte 06H is acknowledged, returns the configuration to 8CH and pulses `soft_reset_o` for one cycle. Data byte 04H is acknowledged with no effect. Any other general-call data byte is not acknowledged.
- R7: An address byte of the form 00001xxx is never acknowledged. It sets `hs_mode_o`, which stays set through repeated STARTs and clears at the next STOP.
- R8: A START during an active transfer (repeated START) restarts address decoding.
- R9: When the master does not acknowledge a read byte, the slave releases SDA until the next START or STOP.
- R10: `sda_oe_o` changes only in the cycle after a detected SCL falling edge, START or STOP.
- R11: After reset the configuration reads 8CH, SDA is released and `hs_mode_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| result_i | input | 16 | Latest conversion result, two's complement |
| cfg_o | output | 8 | Configuration register |
| conv_start_o | output | 1 | One-cycle request to start a conversion |
| soft_reset_o | output | 1 | One-cycle general-call reset request |
| hs_mode_o | output | 1 | High-speed master code seen since the last STOP |

## Verification
The checker enforces four rules on every cycle. The data-line enable moves only after a clock fall, START or STOP. The reserved configuration bits stay zero. The start and reset pulses last a single cycle, and a general-call reset leaves the default configuration behind it. A STOP releases the data line and clears the high-speed flag. The directed bus transfers cover what only whole frames can show: the acknowledge decision for each kind of byte, the read byte order and FFH padding, first-byte-only writes, and repeated STARTs. They also show that the slave goes silent after a master NACK.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_TX, ST_SKIP} bus_state_e;
  typedef enum logic [1:0] {K_ADDR, K_WR, K_GC} byte_kind_e;

  localparam logic [7:0] CFG_DEFAULT  = 8'h8C;
  localparam logic [7:0] GC_CODE_RST  = 8'h06;
  localparam logic [7:0] GC_CODE_KEEP = 8'h04;
  localparam logic [3:0] ADDR_HIGH    = 4'b1001;
  localparam logic [4:0] HS_PREFIX    = 5'b00001;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] prev_q;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= {pipe_q[STAGES-2:0], raw[g]};
    end
    assign lvl[g] = pipe_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl;
  end

  // bit 1 = clock line, bit 0 = data line
  assign sda_lvl   = lvl[0];
  assign scl_rise  = lvl[1] & ~prev_q[1];
  assign scl_fall  = ~lvl[1] & prev_q[1];
  assign start_evt = lvl[1] & prev_q[1] & prev_q[0] & ~lvl[0];
  assign stop_evt  = lvl[1] & prev_q[1] & ~prev_q[0] & lvl[0];
endmodule

// File: rtl/i2cs_cfg_reg.sv
module i2cs_cfg_reg
  import i2cs_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             gc_reset,
  output logic [CFG_W-1:0] cfg,
  output logic             conv_start,
  output logic             soft_reset
);
  logic [CFG_W-1:0] cfg_n;

  always_comb begin
    cfg_n = cfg;
    if (gc_reset)   cfg_n = CFG_DEFAULT;
    else if (wr_en) cfg_n = {wr_data[7], 2'b00, wr_data[4:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg        <= CFG_DEFAULT;
      conv_start <= 1'b0;
      soft_reset <= 1'b0;
    end else begin
      cfg        <= cfg_n;
      conv_start <= wr_en & wr_data[7] & ~gc_reset;
      soft_reset <= gc_reset;
    end
  end
endmodule

// File: rtl/conv_i2c_slave.sv
module conv_i2c_slave
  import i2cs_pkg::*;
#(
  parameter logic [2:0] ADDR_LOW    = 3'b000,
  parameter int         SYNC_STAGES = 2,
  parameter int         RES_W       = 16,
  parameter int         CFG_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [RES_W-1:0] result_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             conv_start_o,
  output logic             soft_reset_o,
  output logic             hs_mode_o
);
  localparam logic [6:0] DEV_ADDR = {ADDR_HIGH, ADDR_LOW};
  localparam logic [3:0] BITS     = 4'd8;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  logic             cfg_we, gc_rst;
  logic [CFG_W-1:0] cfg_wd;

  i2cs_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_core_n), .wr_en(cfg_we), .wr_data(cfg_wd),
    .gc_reset(gc_rst), .cfg(cfg_o), .conv_start(conv_start_o),
    .soft_reset(soft_reset_o)
  );

  bus_state_e       state_q, state_n;
  byte_kind_e       kind_q, kind_n;
  logic [3:0]       bitcnt_q, bitcnt_n;
  logic [7:0]       shreg_q, shreg_n;
  logic             drive_q, drive_n;
  logic             ack_q, ack_n;
  logic [1:0]       rd_idx_q, rd_idx_n;
  logic             wr_done_q, wr_done_n;
  logic             hs_q, hs_n;
  logic [RES_W-1:0] res_q, res_n;

  function automatic logic [7:0] rd_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    rd_byte = res_q[RES_W-1 -: 8];
      2'd1:    rd_byte = res_q[7:0];
      2'd2:    rd_byte = cfg_o;
      default: rd_byte = 8'hFF;
    endcase
  endfunction

  logic       addr_hit, addr_gc, addr_hs, byte_ack;
  logic [7:0] next_tx;

  assign addr_hit = (shreg_q[7:1] == DEV_ADDR);
  assign addr_gc  = (shreg_q == 8'h00);
  assign addr_hs  = (shreg_q[7:3] == HS_PREFIX);
  assign next_tx  = rd_byte(rd_idx_q);

  always_comb begin
    byte_ack = 1'b0;
    case (kind_q)
      K_ADDR:  byte_ack = addr_hit | addr_gc;
      K_WR:    byte_ack = ~wr_done_q;
      default: byte_ack = (shreg_q == GC_CODE_RST) | (shreg_q == GC_CODE_KEEP);
    endcase
  end

  always_comb begin
    state_n = state_q;  kind_n = kind_q;  bitcnt_n = bitcnt_q;
    shreg_n = shreg_q;  drive_n = drive_q; ack_n = ack_q;
    rd_idx_n = rd_idx_q; wr_done_n = wr_done_q; hs_n = hs_q; res_n = res_q;
    cfg_we = 1'b0; cfg_wd = shreg_q; gc_rst = 1'b0;

    if (stop_evt) begin
      state_n = ST_IDLE; drive_n = 1'b0; hs_n = 1'b0; bitcnt_n = '0;
    end else if (start_evt) begin
      state_n = ST_RX; kind_n = K_ADDR; bitcnt_n = '0;
      drive_n = 1'b0; wr_done_n = 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise && bitcnt_q <= BITS) begin
            if (bitcnt_q < BITS) shreg_n = {shreg_q[6:0], sda_lvl};
            bitcnt_n = bitcnt_q + 4'd1;
          end
          if (scl_fall && bitcnt_q == BITS) begin
            ack_n   = byte_ack;
            drive_n = byte_ack;
            if (kind_q == K_ADDR) begin
              if (addr_hs)  hs_n  = 1'b1;
              if (addr_hit) res_n = result_i;
            end else if (kind_q == K_WR && byte_ack) begin
              cfg_we = 1'b1; wr_done_n = 1'b1;
            end else if (kind_q == K_GC && shreg_q == GC_CODE_RST) begin
              gc_rst = 1'b1;
            end
          end else if (scl_fall && bitcnt_q == BITS + 4'd1) begin
            drive_n  = 1'b0;
            bitcnt_n = '0;
            if (!ack_q) state_n = ST_SKIP;
            else if (kind_q == K_ADDR) begin
              if (addr_hit && shreg_q[0]) begin
                state_n  = ST_TX;
                shreg_n  = rd_byte(2'd0);
                drive_n  = ~res_q[RES_W-1];
                rd_idx_n = 2'd1;
              end else if (addr_hit) kind_n = K_WR;
              else                   kind_n = K_GC;
            end
          end
        end
        ST_TX: begin
          if (scl_rise && bitcnt_q <= BITS) begin
            bitcnt_n = bitcnt_q + 4'd1;
            if (bitcnt_q == BITS) ack_n = ~sda_lvl;
          end
          if (scl_fall) begin
            if (bitcnt_q >= 4'd1 && bitcnt_q < BITS) begin
              shreg_n = {shreg_q[6:0], 1'b1};
              drive_n = ~shreg_q[6];
            end else if (bitcnt_q == BITS) begin
              drive_n = 1'b0;
            end else if (bitcnt_q == BITS + 4'd1) begin
              bitcnt_n = '0;
              if (ack_q) begin
                shreg_n  = next_tx;
                drive_n  = ~next_tx[7];
                rd_idx_n = (rd_idx_q == 2'd3) ? 2'd3 : rd_idx_q + 2'd1;
              end else begin
                state_n = ST_SKIP; drive_n = 1'b0;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;  kind_q <= K_ADDR; bitcnt_q <= '0;
      shreg_q <= '0;       drive_q <= 1'b0;  ack_q <= 1'b0;
      rd_idx_q <= '0;      wr_done_q <= 1'b0; hs_q <= 1'b0;
      res_q <= '0;
    end else begin
      state_q <= state_n;  kind_q <= kind_n; bitcnt_q <= bitcnt_n;
      shreg_q <= shreg_n;  drive_q <= drive_n; ack_q <= ack_n;
      rd_idx_q <= rd_idx_n; wr_done_q <= wr_done_n; hs_q <= hs_n;
      res_q <= res_n;
    end
  end

  assign sda_oe_o  = drive_q;
  assign hs_mode_o = hs_q;
endmodule

// File: rtl/conv_i2c_slave_chk.sv
module conv_i2c_slave_chk #(
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_fall,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             sda_oe_o,
  input logic [CFG_W-1:0] cfg_o,
  input logic             conv_start_o,
  input logic             soft_reset_o,
  input logic             hs_mode_o
);
  assert_sda_moves_after_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> $past(scl_fall | start_evt | stop_evt));

  assert_reserved_bits_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[6:5] == 2'b00);

  assert_start_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);

  assert_gc_reset_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset_o |=> (cfg_o == 8'h8C) && !soft_reset_o);

  assert_hs_clears_on_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !hs_mode_o);

  assert_release_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe_o);
endmodule

bind conv_i2c_slave conv_i2c_slave_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .scl_fall(scl_fall), .start_evt(start_evt),
  .stop_evt(stop_evt), .sda_oe_o(sda_oe_o), .cfg_o(cfg_o),
  .conv_start_o(conv_start_o), .soft_reset_o(soft_reset_o), .hs_mode_o(hs_mode_o)
);

// File: tb/conv_i2c_slave_test.sv
`timescale 1ns/1ps
module conv_i2c_slave_test;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic        sda_line;
  logic [15:0] result;
  logic [7:0]  cfg;
  logic        conv_start, soft_reset, hs_mode;

  int checks = 0;
  int errors = 0;
  int start_cnt = 0;
  int reset_cnt = 0;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  conv_i2c_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .result_i(result), .cfg_o(cfg),
    .conv_start_o(conv_start), .soft_reset_o(soft_reset), .hs_mode_o(hs_mode)
  );

  always @(posedge clk) begin
    if (conv_start) start_cnt <= start_cnt + 1;
    if (soft_reset) reset_cnt <= reset_cnt + 1;
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    ack = ~sda_line;
    scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl_m = 1'b1; wq(); b = {b[6:0], sda_line}; scl_m = 1'b0;
    end
    wq(); sda_m = ~give_ack; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic t_reset_state();
    chk("R11 cfg", cfg, 8'h8C);
    chk("R11 sda", sda_oe, 0);
    chk("R11 hs", hs_mode, 0);
  endtask

  task automatic t_read_order();
    logic a; logic [7:0] b;
    result = 16'hA55A;
    bus_start(); send_byte(8'h91, a); chk("R1 addr ack", a, 1);
    recv_byte(1, b); chk("R2 high", b, 8'hA5);
    recv_byte(1, b); chk("R2 low", b, 8'h5A);
    recv_byte(1, b); chk("R2 cfg", b, 8'h8C);
    recv_byte(1, b); chk("R3 pad4", b, 8'hFF);
    recv_byte(0, b); chk("R3 pad5", b, 8'hFF);
    bus_stop();
  endtask

  task automatic t_write();
    logic a; int s0;
    s0 = start_cnt;
    bus_start(); send_byte(8'h90, a); chk("R1 write addr", a, 1);
    send_byte(8'hFF, a); chk("R4 data ack", a, 1);
    chk("R4 cfg masked", cfg, 8'h9F);
    chk("R4 start pulse", start_cnt - s0, 1);
    send_byte(8'h03, a); chk("R5 second nack", a, 0);
    bus_stop();
    chk("R5 cfg kept", cfg, 8'h9F);
    bus_start(); send_byte(8'h90, a); send_byte(8'h0D, a); bus_stop();
    chk("R4 no pulse", start_cnt - s0, 1);
    chk("R4 cfg new", cfg, 8'h0D);
  endtask

  task automatic t_wrong_addr();
    logic a;
    bus_start(); send_byte(8'h92, a); chk("R1 other nack", a, 0);
    send_byte(8'h80, a); bus_stop();
    chk("R1 cfg kept", cfg, 8'h0D);
  endtask

  task automatic t_gcall();
    logic a; int r0;
    r0 = reset_cnt;
    bus_start(); send_byte(8'h00, a); chk("R6 gc addr", a, 1);
    send_byte(8'h04, a); chk("R6 04 ack", a, 1); bus_stop();
    chk("R6 04 no effect", cfg, 8'h0D);
    bus_start(); send_byte(8'h00, a); send_byte(8'h12, a); chk("R6 other nack", a, 0);
    bus_stop();
    chk("R6 other no reset", reset_cnt - r0, 0);
    bus_start(); send_byte(8'h00, a); send_byte(8'h06, a); chk("R6 06 ack", a, 1);
    bus_stop();
    chk("R6 cfg default", cfg, 8'h8C);
    chk("R6 reset pulse", reset_cnt - r0, 1);
  endtask

  task automatic t_hs_and_restart();
    logic a; logic [7:0] b;
    result = 16'h1234;
    bus_start(); send_byte(8'h0B, a); chk("R7 hs nack", a, 0);
    chk("R7 hs set", hs_mode, 1);
    bus_start(); send_byte(8'h90, a); chk("R8 restart addr", a, 1);
    send_byte(8'h05, a);
    chk("R7 hs held", hs_mode, 1);
    bus_start(); send_byte(8'h91, a); chk("R8 restart read", a, 1);
    recv_byte(1, b); recv_byte(1, b); recv_byte(0, b);
    chk("R8 cfg via restart", b, 8'h05);
    bus_stop();
    chk("R7 hs cleared", hs_mode, 0);
  endtask

  task automatic t_master_nack();
    logic a; logic [7:0] b;
    result = 16'h0034;
    bus_start(); send_byte(8'h91, a);
    recv_byte(0, b); chk("R9 first byte", b, 8'h00);
    recv_byte(1, b); chk("R9 released", b, 8'hFF);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    result = 16'h0000;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset_state();
    t_read_order();
    t_write();
    t_wrong_addr();
    t_gcall();
    t_hs_and_restart();
    t_master_nack();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule